// File: doc/BRIEF.md
# Operand Forwarding Select Unit

This block picks where each ALU operand of the instruction in the execute stage of a five-stage in-order pipeline comes from. There are three possible sources. The first is the register value latched into the ID/EX register. The second is the ALU result held in the EX/MEM register, which is one instruction older. The third is the final writeback value in MEM/WB, which is two instructions older and may be an ALU result or load data. The block compares the execute-stage source register numbers with the destination numbers of the two older instructions. It qualifies each match with that instruction's write enable, and gives each operand its own two-bit select together with the muxed operand value.

The same matching logic also serves the decode stage. When a decode-stage source reads the register that writeback is writing in this cycle, the write data replaces the stale register-file read data. The block is purely combinational and holds no state. The hazard unit is expected to stall any instruction that consumes a load result still in EX/MEM. This block only makes sure no stale value is forwarded in that case.

Top module: `fwd_select_unit`

## Requirements
- R1: If an operand's source register matches the EX/MEM destination, the EX/MEM write enable is high and the EX/MEM instruction is not a load, the select is 2'b10 and the operand output equals the EX/MEM ALU result.
- R2: If R1 does not apply and no EX/MEM load matches, the select is 2'b01 and the operand output equals the writeback data when the source matches the MEM/WB destination and the MEM/WB write enable is high.
- R3: If both EX/MEM and MEM/WB qualify for the same operand, the younger EX/MEM result wins and the select is 2'b10.
- R4: Source register 0 never forwards in either stage, even when an older instruction records a write to register 0.
- R5: A destination whose write enable is low never causes forwarding.
- R6: If a load in EX/MEM matches an operand's source with its write enable high, the select is 2'b00 even when MEM/WB also matches, so that older writeback data is never forwarded.
- R7: With no qualifying match, the select is 2'b00 and the operand output equals the ID/EX register value. The value 2'b11 is never produced.
- R8: Each decode-stage source that matches the MEM/WB destination, with the MEM/WB write enable high and the source nonzero, raises its bypass flag and outputs the writeback data. Otherwise the flag is low and the register-file read data passes through.
- R9: Each operand and each decode source is resolved only from its own source number. The selects for operands A (index 0) and B (index 1) are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_i | input | N_OPS x REG_W | Execute-stage source register numbers, index 0 = operand A |
| ex_rf_data_i | input | N_OPS x DATA_W | Operand values latched in ID/EX |
| exm_dst_i | input | REG_W | EX/MEM destination register |
| exm_wen_i | input | 1 | EX/MEM register write enable |
| exm_load_i | input | 1 | EX/MEM instruction is a load |
| exm_alu_i | input | DATA_W | EX/MEM ALU result |
| mwb_dst_i | input | REG_W | MEM/WB destination register |
| mwb_wen_i | input | 1 | MEM/WB register write enable |
| wb_data_i | input | DATA_W | Final writeback value |
| id_src_i | input | N_ID x REG_W | Decode-stage source register numbers |
| id_rf_data_i | input | N_ID x DATA_W | Register-file read data for the decode sources |
| ex_sel_o | output | N_OPS x 2 | Per-operand select: 00 register, 10 EX/MEM, 01 MEM/WB |
| ex_opnd_o | output | N_OPS x DATA_W | Selected operand values |
| id_byp_o | output | N_ID | Decode-source bypass taken |
| id_data_o | output | N_ID x DATA_W | Decode-source data after bypass |

## Verification
The bench runs a full sweep over four register numbers (including register 0) for the operand source, the EX/MEM destination and the MEM/WB destination. For each combination it crosses both write enables with the load flag. Every priority case therefore comes up: mem-only, wb-only, both, load shadowing, disabled writes and the zero register. Operand B and the decode sources get permuted register numbers, so a swap or cross-coupling between indices shows up as a mismatch. Each source is given a distinct data tag, so the operand values also show which mux leg was taken.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic             wen_i,
  output logic             hit_o
);
  logic src_nz;
  assign src_nz = |src_i;
  assign hit_o  = wen_i & src_nz & (src_i == dst_i);

  always_comb begin
    if (src_i == '0) assert_zero_no_hit_R4: assert (!hit_o);
    if (!wen_i)      assert_wen_gate_R5: assert (!hit_o);
  end
endmodule

// File: rtl/fwd_ex_sel.sv
module fwd_ex_sel
  import fwd_pkg::*;
(
  input  logic     mem_hit_i,
  input  logic     mem_load_i,
  input  logic     wb_hit_i,
  output fwd_sel_e sel_o
);
  always_comb begin
    if (mem_hit_i)     sel_o = mem_load_i ? SEL_RF : SEL_MEM; // load shadows older WB value
    else if (wb_hit_i) sel_o = SEL_WB;
    else               sel_o = SEL_RF;
  end

  always_comb begin
    assert_sel_legal_R7: assert (sel_o != fwd_sel_e'(2'b11));
    if (mem_hit_i && !mem_load_i) assert_mem_prio_R3: assert (sel_o == SEL_MEM);
    if (mem_hit_i && mem_load_i)  assert_load_block_R6: assert (sel_o == SEL_RF);
  end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwd_sel_e          sel_i,
  input  logic [DATA_W-1:0] rf_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] wb_i,
  output logic [DATA_W-1:0] out_o
);
  always_comb begin
    unique case (sel_i)
      SEL_MEM: out_o = mem_i;
      SEL_WB:  out_o = wb_i;
      default: out_o = rf_i;
    endcase
  end
endmodule

// File: rtl/fwd_select_unit.sv
module fwd_select_unit
  import fwd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int N_OPS  = 2,
  parameter int N_ID   = 2
) (
  input  logic [N_OPS-1:0][REG_W-1:0]  ex_src_i,
  input  logic [N_OPS-1:0][DATA_W-1:0] ex_rf_data_i,
  input  logic [REG_W-1:0]             exm_dst_i,
  input  logic                         exm_wen_i,
  input  logic                         exm_load_i,
  input  logic [DATA_W-1:0]            exm_alu_i,
  input  logic [REG_W-1:0]             mwb_dst_i,
  input  logic                         mwb_wen_i,
  input  logic [DATA_W-1:0]            wb_data_i,
  input  logic [N_ID-1:0][REG_W-1:0]   id_src_i,
  input  logic [N_ID-1:0][DATA_W-1:0]  id_rf_data_i,
  output logic [N_OPS-1:0][1:0]        ex_sel_o,
  output logic [N_OPS-1:0][DATA_W-1:0] ex_opnd_o,
  output logic [N_ID-1:0]              id_byp_o,
  output logic [N_ID-1:0][DATA_W-1:0]  id_data_o
);
  localparam fwd_sel_e ID_SEL_BYP = SEL_WB;

  for (genvar g = 0; g < N_OPS; g++) begin : g_ex
    logic     mem_hit, wb_hit;
    fwd_sel_e sel;

    fwd_match #(.REG_W(REG_W)) u_mem_match (
      .src_i(ex_src_i[g]), .dst_i(exm_dst_i), .wen_i(exm_wen_i), .hit_o(mem_hit)
    );
    fwd_match #(.REG_W(REG_W)) u_wb_match (
      .src_i(ex_src_i[g]), .dst_i(mwb_dst_i), .wen_i(mwb_wen_i), .hit_o(wb_hit)
    );
    fwd_ex_sel u_sel (
      .mem_hit_i(mem_hit), .mem_load_i(exm_load_i), .wb_hit_i(wb_hit), .sel_o(sel)
    );
    fwd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel_i(sel), .rf_i(ex_rf_data_i[g]), .mem_i(exm_alu_i), .wb_i(wb_data_i),
      .out_o(ex_opnd_o[g])
    );
    assign ex_sel_o[g] = sel;

    always_comb begin
      if (sel == SEL_MEM) assert_opnd_mem_R1: assert (ex_opnd_o[g] == exm_alu_i);
      if (sel == SEL_WB)  assert_opnd_wb_R2: assert (ex_opnd_o[g] == wb_data_i);
      if (sel == SEL_RF)  assert_opnd_rf_R7: assert (ex_opnd_o[g] == ex_rf_data_i[g]);
      if (ex_src_i[g] == '0) assert_ex_zero_R4: assert (ex_sel_o[g] == 2'b00);
    end
  end

  for (genvar g = 0; g < N_ID; g++) begin : g_id
    logic hit;
    fwd_match #(.REG_W(REG_W)) u_id_match (
      .src_i(id_src_i[g]), .dst_i(mwb_dst_i), .wen_i(mwb_wen_i), .hit_o(hit)
    );
    fwd_mux #(.DATA_W(DATA_W)) u_id_mux (
      .sel_i(hit ? ID_SEL_BYP : SEL_RF), .rf_i(id_rf_data_i[g]), .mem_i(exm_alu_i),
      .wb_i(wb_data_i), .out_o(id_data_o[g])
    );
    assign id_byp_o[g] = hit;

    always_comb begin
      if (id_byp_o[g])  assert_id_byp_data_R8: assert (id_data_o[g] == wb_data_i);
      if (!id_byp_o[g]) assert_id_pass_R8: assert (id_data_o[g] == id_rf_data_i[g]);
      if (id_src_i[g] == '0) assert_id_zero_R4: assert (!id_byp_o[g]);
    end
  end
endmodule

// File: tb/fwd_select_unit_tb.sv
module fwd_select_unit_tb_top;
  localparam int RW = 5, DW = 32, NO = 2, NI = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [NO-1:0][RW-1:0] ex_src = '0;
  logic [NO-1:0][DW-1:0] ex_rf = '0;
  logic [RW-1:0] exm_dst = '0, mwb_dst = '0;
  logic exm_wen = 1'b0, exm_load = 1'b0, mwb_wen = 1'b0;
  logic [DW-1:0] exm_alu = '0, wb_data = '0;
  logic [NI-1:0][RW-1:0] id_src = '0;
  logic [NI-1:0][DW-1:0] id_rf = '0;
  logic [NO-1:0][1:0] ex_sel;
  logic [NO-1:0][DW-1:0] ex_opnd;
  logic [NI-1:0] id_byp;
  logic [NI-1:0][DW-1:0] id_data;

  int n_chk = 0, n_bad = 0;

  fwd_select_unit #(.REG_W(RW), .DATA_W(DW), .N_OPS(NO), .N_ID(NI)) dut_i (
    .ex_src_i(ex_src), .ex_rf_data_i(ex_rf), .exm_dst_i(exm_dst), .exm_wen_i(exm_wen),
    .exm_load_i(exm_load), .exm_alu_i(exm_alu), .mwb_dst_i(mwb_dst), .mwb_wen_i(mwb_wen),
    .wb_data_i(wb_data), .id_src_i(id_src), .id_rf_data_i(id_rf), .ex_sel_o(ex_sel),
    .ex_opnd_o(ex_opnd), .id_byp_o(id_byp), .id_data_o(id_data)
  );

  function automatic logic [1:0] exp_sel(int s);
    logic mh, wh;
    mh = (s != 0) && exm_wen && (exm_dst == RW'(s));
    wh = (s != 0) && mwb_wen && (mwb_dst == RW'(s));
    if (mh) return exm_load ? 2'b00 : 2'b10;
    if (wh) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tag_of(int s);
    logic mh, wh;
    mh = (exm_dst == RW'(s));
    wh = (mwb_dst == RW'(s));
    if (s == 0) return "R4";
    if (mh && exm_wen && exm_load) return "R6";
    if (mh && exm_wen && wh && mwb_wen) return "R3";
    if (mh && exm_wen) return "R1";
    if (wh && mwb_wen) return "R2";
    if (mh || wh) return "R5";
    return "R7";
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    for (int k = 0; k < NO; k++) begin
      logic [1:0] es;
      logic [DW-1:0] ed;
      es = exp_sel(int'(ex_src[k]));
      ed = (es == 2'b10) ? exm_alu : (es == 2'b01) ? wb_data : ex_rf[k];
      chk({tag_of(int'(ex_src[k])), (k == 0) ? " sel A" : " sel B R9"}, 64'(ex_sel[k]), 64'(es));
      chk({tag_of(int'(ex_src[k])), " opnd"}, 64'(ex_opnd[k]), 64'(ed));
    end
    for (int k = 0; k < NI; k++) begin
      logic eb;
      eb = (id_src[k] != 0) && mwb_wen && (mwb_dst == id_src[k]);
      chk(id_src[k] == 0 ? "R8 R4 id" : "R8 id byp", 64'(id_byp[k]), 64'(eb));
      chk("R8 id data", 64'(id_data[k]), 64'(eb ? wb_data : id_rf[k]));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    ex_rf[0] = 32'hA000_0000; ex_rf[1] = 32'hA100_0001;
    id_rf[0] = 32'hD000_0000; id_rf[1] = 32'hD100_0001;
    exm_alu  = 32'hB0B0_B0B0; wb_data  = 32'hC0C0_C0C0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R7 idle sel A", 64'(ex_sel[0]), 64'd0);
    chk("R7 idle sel B", 64'(ex_sel[1]), 64'd0);

    // R4: write to r0 recorded in both stages
    @(posedge clk);
    ex_src[0] = '0; exm_dst = '0; mwb_dst = '0; exm_wen = 1'b1; mwb_wen = 1'b1;
    id_src[0] = '0;
    @(negedge clk);
    chk("R4 ex r0", 64'(ex_sel[0]), 64'd0);
    chk("R4 id r0", 64'(id_byp[0]), 64'd0);

    // R3: same register in both stages
    @(posedge clk);
    ex_src[0] = 5'd7; exm_dst = 5'd7; mwb_dst = 5'd7; exm_load = 1'b0;
    @(negedge clk);
    chk("R3 prio", 64'(ex_sel[0]), 64'b10);
    chk("R3 data", 64'(ex_opnd[0]), 64'(exm_alu));

    // R6: load in EX/MEM shadows WB match
    @(posedge clk);
    exm_load = 1'b1;
    @(negedge clk);
    chk("R6 load", 64'(ex_sel[0]), 64'b00);
    exm_load = 1'b0;

    // R9: A from MEM, B from WB
    @(posedge clk);
    ex_src[0] = 5'd3; ex_src[1] = 5'd9; exm_dst = 5'd3; mwb_dst = 5'd9;
    @(negedge clk);
    chk("R9 A", 64'(ex_sel[0]), 64'b10);
    chk("R9 B", 64'(ex_sel[1]), 64'b01);

    // sweep of the small register space
    for (int s = 0; s < 4; s++)
      for (int md = 0; md < 4; md++)
        for (int wd = 0; wd < 4; wd++)
          for (int f = 0; f < 8; f++) begin
            @(posedge clk);
            ex_src[0] = RW'(s);
            ex_src[1] = RW'((s + 2) % 4);
            id_src[0] = RW'(s);
            id_src[1] = RW'((s + 1) % 4);
            exm_dst = RW'(md); mwb_dst = RW'(wd);
            exm_wen = f[0]; mwb_wen = f[1]; exm_load = f[2];
            exm_alu = 32'hB000_0000 | 32'(s * 64 + md * 16 + wd * 4 + f);
            wb_data = 32'hC000_0000 | 32'(f * 7 + wd);
            @(negedge clk);
            check_all();
          end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule